// File: doc/BRIEF.md
# Test Access Port Controller with Data Register Selection

This block is the serial test port of a chip. All of its logic runs on the test clock, which has no fixed relation to any system clock. A sixteen-state controller follows the mode-select line. A 4-bit instruction register holds the active test instruction. Three data paths can sit between serial-in and serial-out: a one-bit bypass stage, a 32-bit identification register, and the external boundary register, whose serial output comes back in on `bsScanIn`.

The decoded instruction does three things. It selects the data path. It qualifies the capture, shift and update strobes sent to the boundary cells. It raises mode outputs that tell the pad logic to drive pins from the boundary register or to float them. The block contains neither the boundary cells nor any self-test engine.

Opcodes: EXTEST 4'h0, SAMPLE/PRELOAD 4'h1, IDCODE 4'h2, USERCODE 4'h3, CLAMP 4'h4, HIGHZ 4'h5, BYPASS 4'hF. Every other code acts as BYPASS. All registers shift least significant bit first.

Top module: `jtagTap`

## Requirements
- R1: `trstN` low forces the controller into Test-Logic-Reset at once. Five consecutive rising test-clock edges with `tmsIn` high reach the same state from any state. In that state the active instruction becomes IDCODE (4'h2).
- R2: In Capture-IR the instruction shift register loads 4'b0001, so the first bit shifted out is 1 and the next three are 0.
- R3: A shifted instruction takes effect only on the falling edge in Update-IR. The mode outputs do not change during Shift-IR or Exit1-IR.
- R4: BYPASS (4'hF) and every unassigned opcode place the one-bit bypass stage on the path. That stage captures 0, so serial-out is 0 first and then serial-in delayed by one shift.
- R5: IDCODE (4'h2) captures {version[31:28], part[27:12], manufacturer[11:1], 1'b1} from parameters and shifts it out LSB first, followed by the serial-in bits.
- R6: USERCODE (4'h3) uses the same 32-bit path but captures the `userCode` input present at the Capture-DR rising edge.
- R7: EXTEST (4'h0) and SAMPLE/PRELOAD (4'h1) select the boundary path. `tdoOut` follows `bsScanIn`, and `bsCapture`, `bsShift` and `bsUpdate` are high exactly in Capture-DR, Shift-DR and Update-DR. Under every other instruction these strobes stay low. `modeDriveBoundary` is high for EXTEST only of the two.
- R8: CLAMP (4'h4) selects the bypass stage and holds `modeDriveBoundary` high.
- R9: HIGHZ (4'h5) selects the bypass stage and holds `modeHighZ` high.
- R10: `tdoOut` and `tdoEn` change only on falling test-clock edges. `tdoEn` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low test reset |
| tmsIn | input | 1 | Mode select, sampled on the rising edge |
| tdiIn | input | 1 | Serial data in |
| userCode | input | 32 | Programmable code captured under USERCODE |
| bsScanIn | input | 1 | Serial return from the external boundary register |
| tdoOut | output | 1 | Serial data out, updated on the falling edge |
| tdoEn | output | 1 | Output enable for serial-out |
| bsCapture | output | 1 | Boundary capture strobe |
| bsShift | output | 1 | Boundary shift strobe |
| bsUpdate | output | 1 | Boundary update strobe |
| modeBoundarySel | output | 1 | Boundary register is the selected data path |
| modeDriveBoundary | output | 1 | Pins are driven from boundary cells |
| modeHighZ | output | 1 | Pins are floated |

## Verification
Each opcode is loaded and then followed by a 40-bit data shift with a fixed pattern. The length and content of what comes back show which path is selected: a one-bit delay with a leading 0 means bypass, a 32-bit captured word means identification, and a constant stream means the boundary return. Two different programmable codes separate USERCODE capture from the fixed word. Several opcodes share the bypass path and differ only in their mode outputs, so their mode outputs are compared too. The strobe counts for each shift show whether the boundary strobes are gated correctly. Directed sequences cover both reset routes, the instruction capture pattern, the timing of instruction commit, and the falling-edge timing of the output enable.

// File: rtl/tapPkg.sv
package tapPkg;
  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'h2;
  localparam logic [IR_W-1:0] OP_USERCODE = 4'h3;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'h4;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'h5;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
  } tapStateT;

  typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_BS } pathT;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobeT;
endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapPkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tmsIn,
  output tapStrobeT strobe
);
  tapStateT state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:    nextState = tmsIn ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tmsIn ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tmsIn ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tmsIn ? ST_EX1_DR   : ST_SH_DR;
      ST_SH_DR:    nextState = tmsIn ? ST_EX1_DR   : ST_SH_DR;
      ST_EX1_DR:   nextState = tmsIn ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tmsIn ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   nextState = tmsIn ? ST_UPD_DR   : ST_SH_DR;
      ST_UPD_DR:   nextState = tmsIn ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tmsIn ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tmsIn ? ST_EX1_IR   : ST_SH_IR;
      ST_SH_IR:    nextState = tmsIn ? ST_EX1_IR   : ST_SH_IR;
      ST_EX1_IR:   nextState = tmsIn ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tmsIn ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   nextState = tmsIn ? ST_UPD_IR   : ST_SH_IR;
      ST_UPD_IR:   nextState = tmsIn ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strobe.inReset   = (state == ST_RESET);
    strobe.captureIr = (state == ST_CAP_IR);
    strobe.shiftIr   = (state == ST_SH_IR);
    strobe.updateIr  = (state == ST_UPD_IR);
    strobe.captureDr = (state == ST_CAP_DR);
    strobe.shiftDr   = (state == ST_SH_DR);
    strobe.updateDr  = (state == ST_UPD_DR);
  end

  // checker counter: consecutive rising edges with mode select high
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              tmsRun <= '0;
    else if (!tmsIn)         tmsRun <= '0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  a_r1_five_high_resets: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun >= 3'd5) |-> (state == ST_RESET));

  a_r7_one_strobe: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({strobe.captureIr, strobe.shiftIr, strobe.updateIr,
              strobe.captureDr, strobe.shiftDr, strobe.updateDr}));
endmodule

// File: rtl/tapData.sv
module tapData
  import tapPkg::*;
#(
  parameter logic [ID_W-1:0] FIXED_ID = 32'h0000_0001
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdiIn,
  input  logic [ID_W-1:0] userCode,
  input  logic            bsScanIn,
  input  tapStrobeT       strobe,
  output logic            tdoOut,
  output logic            tdoEn,
  output logic            bsCapture,
  output logic            bsShift,
  output logic            bsUpdate,
  output logic            modeBoundarySel,
  output logic            modeDriveBoundary,
  output logic            modeHighZ
);
  logic [IR_W-1:0] irShift, activeIr;
  logic            bypassReg;
  logic [ID_W-1:0] idReg;
  pathT            pathSel;
  logic            useUser, serialNext;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                irShift <= IR_CAPTURE;
    else if (strobe.captureIr) irShift <= IR_CAPTURE;
    else if (strobe.shiftIr)   irShift <= {tdiIn, irShift[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)               activeIr <= OP_IDCODE;
    else if (strobe.inReset)  activeIr <= OP_IDCODE;
    else if (strobe.updateIr) activeIr <= irShift;
  end

  always_comb begin
    pathSel           = PATH_BYP;
    useUser           = 1'b0;
    modeDriveBoundary = 1'b0;
    modeHighZ         = 1'b0;
    unique case (activeIr)
      OP_EXTEST:   begin pathSel = PATH_BS; modeDriveBoundary = 1'b1; end
      OP_SAMPLE:   pathSel = PATH_BS;
      OP_IDCODE:   pathSel = PATH_ID;
      OP_USERCODE: begin pathSel = PATH_ID; useUser = 1'b1; end
      OP_CLAMP:    modeDriveBoundary = 1'b1;
      OP_HIGHZ:    modeHighZ = 1'b1;
      default:     pathSel = PATH_BYP;
    endcase
  end

  assign modeBoundarySel = (pathSel == PATH_BS);
  assign bsCapture = strobe.captureDr & modeBoundarySel;
  assign bsShift   = strobe.shiftDr   & modeBoundarySel;
  assign bsUpdate  = strobe.updateDr  & modeBoundarySel;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                bypassReg <= 1'b0;
    else if (strobe.captureDr) bypassReg <= 1'b0;
    else if (strobe.shiftDr)   bypassReg <= tdiIn;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                idReg <= FIXED_ID;
    else if (strobe.captureDr) idReg <= useUser ? userCode : FIXED_ID;
    else if (strobe.shiftDr && pathSel == PATH_ID)
      idReg <= {tdiIn, idReg[ID_W-1:1]};
  end

  always_comb begin
    if (strobe.shiftIr) serialNext = irShift[0];
    else begin
      unique case (pathSel)
        PATH_ID: serialNext = idReg[0];
        PATH_BS: serialNext = bsScanIn;
        default: serialNext = bypassReg;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoOut <= 1'b0;
      tdoEn  <= 1'b0;
    end else begin
      tdoOut <= serialNext;
      tdoEn  <= strobe.shiftIr | strobe.shiftDr;
    end
  end

  a_r3_ir_holds: assert property (@(posedge tck) disable iff (!trstN)
    (!strobe.updateIr && !strobe.inReset) |-> $stable(activeIr));

  a_r4_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    strobe.captureDr |=> (bypassReg == 1'b0));

  a_r10_enable_in_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strobe.shiftIr || strobe.shiftDr));

  a_r7_no_bs_strobe_off_path: assert property (@(posedge tck) disable iff (!trstN)
    !modeBoundarySel |-> !(bsCapture || bsShift || bsUpdate));
endmodule

// File: rtl/jtagTap.sv
module jtagTap
  import tapPkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA5C1,
  parameter logic [10:0] ID_MFR     = 11'h2B5
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tmsIn,
  input  logic            tdiIn,
  input  logic [ID_W-1:0] userCode,
  input  logic            bsScanIn,
  output logic            tdoOut,
  output logic            tdoEn,
  output logic            bsCapture,
  output logic            bsShift,
  output logic            bsUpdate,
  output logic            modeBoundarySel,
  output logic            modeDriveBoundary,
  output logic            modeHighZ
);
  localparam logic [ID_W-1:0] FIXED_ID = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tapStrobeT strobe;

  tapCtrl u_ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .tmsIn  (tmsIn),
    .strobe (strobe)
  );

  tapData #(.FIXED_ID(FIXED_ID)) u_data (
    .tck               (tck),
    .trstN             (trstN),
    .tdiIn             (tdiIn),
    .userCode          (userCode),
    .bsScanIn          (bsScanIn),
    .strobe            (strobe),
    .tdoOut            (tdoOut),
    .tdoEn             (tdoEn),
    .bsCapture         (bsCapture),
    .bsShift           (bsShift),
    .bsUpdate          (bsUpdate),
    .modeBoundarySel   (modeBoundarySel),
    .modeDriveBoundary (modeDriveBoundary),
    .modeHighZ         (modeHighZ)
  );
endmodule

// File: tb/jtagTap_tb.sv
module jtagTap_tb;
  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'hA5C1;
  localparam logic [10:0] MFR  = 11'h2B5;
  localparam logic [31:0] EXP_ID = {VER, PART, MFR, 1'b1};
  localparam logic [39:0] PAT = 40'hC3_5A96_E71D;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] path;   // 0 bypass, 1 fixed id, 2 user code, 3 boundary
    logic       drive;
    logic       hiz;
  } vecT;

  localparam vecT VECS [0:8] = '{
    '{4'h0, 2'd3, 1'b1, 1'b0},
    '{4'h1, 2'd3, 1'b0, 1'b0},
    '{4'h2, 2'd1, 1'b0, 1'b0},
    '{4'h3, 2'd2, 1'b0, 1'b0},
    '{4'h4, 2'd0, 1'b1, 1'b0},
    '{4'h5, 2'd0, 1'b0, 1'b1},
    '{4'hF, 2'd0, 1'b0, 1'b0},
    '{4'h9, 2'd0, 1'b0, 1'b0},
    '{4'h6, 2'd0, 1'b0, 1'b0}
  };

  logic tck = 1'b0, trstN = 1'b0, tmsIn = 1'b1, tdiIn = 1'b0, bsScanIn = 1'b1;
  logic [31:0] userCode = 32'h1234_5678;
  logic tdoOut, tdoEn, bsCapture, bsShift, bsUpdate;
  logic modeBoundarySel, modeDriveBoundary, modeHighZ;

  int checks = 0, failures = 0;
  int capCnt, shCnt, updCnt;
  bit done = 0;

  always #2 tck = ~tck;

  jtagTap #(.ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR)) u_dut (
    .tck(tck), .trstN(trstN), .tmsIn(tmsIn), .tdiIn(tdiIn), .userCode(userCode),
    .bsScanIn(bsScanIn), .tdoOut(tdoOut), .tdoEn(tdoEn), .bsCapture(bsCapture),
    .bsShift(bsShift), .bsUpdate(bsUpdate), .modeBoundarySel(modeBoundarySel),
    .modeDriveBoundary(modeDriveBoundary), .modeHighZ(modeHighZ));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    tmsIn = tms; tdiIn = tdi;
    @(posedge tck); @(negedge tck); #1;
    capCnt += int'(bsCapture); shCnt += int'(bsShift); updCnt += int'(bsUpdate);
  endtask

  task automatic toIdle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  // from idle, shift op into IR; stop in Exit1-IR when commit==0
  task automatic shiftIr(input logic [3:0] op, input bit commit, output logic [3:0] got);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    got[0] = tdoOut;
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i]);
      if (i < 3) got[i+1] = tdoOut;
    end
    if (commit) begin tick(1'b1, 1'b0); tick(1'b0, 1'b0); end
  endtask

  task automatic shiftDr(input logic [39:0] d, output logic [39:0] got);
    capCnt = 0; shCnt = 0; updCnt = 0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    got[0] = tdoOut;
    for (int i = 0; i < 40; i++) begin
      tick(i == 39, d[i]);
      if (i < 39) got[i+1] = tdoOut;
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  function automatic logic [39:0] expDr(input logic [1:0] path, input logic [39:0] d, input logic [31:0] uc);
    case (path)
      2'd0: return {d[38:0], 1'b0};
      2'd1: return {d[7:0], EXP_ID};
      2'd2: return {d[7:0], uc};
      default: return {40{1'b1}};
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] irGot;
    logic [39:0] drGot;
    capCnt = 0; shCnt = 0; updCnt = 0;
    #9;
    check(tdoEn == 1'b0 && modeDriveBoundary == 1'b0 && modeHighZ == 1'b0, "R1 reset outputs",
          {tdoEn, modeDriveBoundary, modeHighZ}, 0);
    trstN = 1'b1;
    toIdle();
    check(tdoEn == 1'b0, "R10 enable low in idle", tdoEn, 0);

    // R1/R5: idcode is active after reset without loading IR
    shiftDr(PAT, drGot);
    check(drGot == expDr(2'd1, PAT, userCode), "R1 R5 default idcode", drGot, expDr(2'd1, PAT, userCode));

    // vector table: R4 R5 R6 R7 R8 R9
    foreach (VECS[k]) begin
      shiftIr(VECS[k].op, 1'b1, irGot);
      check(irGot == 4'b0001, "R2 capture pattern", irGot, 4'b0001);
      check(modeDriveBoundary == VECS[k].drive && modeHighZ == VECS[k].hiz &&
            modeBoundarySel == (VECS[k].path == 2'd3), "R7 R8 R9 mode outputs",
            {modeBoundarySel, modeDriveBoundary, modeHighZ},
            {VECS[k].path == 2'd3, VECS[k].drive, VECS[k].hiz});
      shiftDr(PAT, drGot);
      check(drGot == expDr(VECS[k].path, PAT, userCode), "R4 R5 R6 R7 data path",
            drGot, expDr(VECS[k].path, PAT, userCode));
      if (VECS[k].path == 2'd3)
        check(capCnt == 1 && shCnt == 40 && updCnt == 1, "R7 boundary strobes",
              {capCnt[15:0], shCnt[15:0], updCnt[15:0]}, {16'd1, 16'd40, 16'd1});
      else
        check(capCnt == 0 && shCnt == 0 && updCnt == 0, "R7 strobes gated off",
              {capCnt[15:0], shCnt[15:0], updCnt[15:0]}, 0);
    end

    // R6: second user code value
    userCode = 32'hFEDC_0BA9;
    shiftIr(4'h3, 1'b1, irGot);
    shiftDr(PAT, drGot);
    check(drGot == expDr(2'd2, PAT, userCode), "R6 second user code", drGot, expDr(2'd2, PAT, userCode));

    // R3: EXTEST shifted but not committed while in Exit1-IR
    shiftIr(4'h5, 1'b1, irGot);
    shiftIr(4'h0, 1'b0, irGot);
    check(modeDriveBoundary == 1'b0 && modeHighZ == 1'b1, "R3 no change before update",
          {modeDriveBoundary, modeHighZ}, 2'b01);
    tmsIn = 1'b1;
    @(posedge tck); #1;
    check(modeDriveBoundary == 1'b0, "R3 update waits for falling edge", modeDriveBoundary, 0);
    @(negedge tck); #1;
    check(modeDriveBoundary == 1'b1 && modeHighZ == 1'b0, "R3 committed in update",
          {modeDriveBoundary, modeHighZ}, 2'b10);
    tick(1'b0, 1'b0);

    // R10: enable rises at the falling edge after entering Shift-DR
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    tmsIn = 1'b0;
    @(posedge tck); #1;
    check(tdoEn == 1'b0, "R10 enable not at rising edge", tdoEn, 0);
    @(negedge tck); #1;
    check(tdoEn == 1'b1, "R10 enable at falling edge", tdoEn, 1);

    // R1: five high ticks from inside Shift-DR reach reset and idcode
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    check(tdoEn == 1'b0 && modeDriveBoundary == 1'b0, "R1 five-tick reset",
          {tdoEn, modeDriveBoundary}, 0);
    tick(1'b0, 1'b0);
    shiftDr(PAT, drGot);
    check(drGot == expDr(2'd1, PAT, userCode), "R1 idcode after tms reset", drGot, expDr(2'd1, PAT, userCode));

    // R1: asynchronous reset mid-shift
    shiftIr(4'h4, 1'b1, irGot);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    #0.5 trstN = 1'b0;
    #0.5;
    check(tdoEn == 1'b0 && modeDriveBoundary == 1'b0, "R1 async reset",
          {tdoEn, modeDriveBoundary}, 0);
    @(negedge tck); #1 trstN = 1'b1;
    tick(1'b0, 1'b0);
    shiftDr(PAT, drGot);
    check(drGot == expDr(2'd1, PAT, userCode), "R1 idcode after async reset", drGot, expDr(2'd1, PAT, userCode));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule